// File: doc/BRIEF.md
# Pipelined Stage-Chained Synchronous FIFO

This block builds one deep first-in-first-out buffer from a parameterised number of identical buffer stages placed in series on a single clock. A producer writes words into the head stage. A consumer reads words from the tail stage. Between neighbouring stages a small handshake link moves one word per clock. The link reads the upstream stage while that stage holds data and the downstream stage has room. It then writes the word into the downstream stage on the following clock. The link gates that write with a copy of the upstream empty flag delayed by one clock.

The external interface uses plain flags and active-low strobes. A producer may offer a word on any cycle with `wr_n` low. The word is taken on the rising edge only if `wr_full` was low before that edge, so `wr_full` acts as the inverse of a ready signal and a refused word is simply dropped. A consumer may pull on any cycle with `rd_n` low. The pull takes effect only if `rd_empty` was low, and the word appears on `rd_data` after that edge. None of the internal stage flags is visible outside.

Top module: `fifo_chain`

## Requirements
- R1: While `rst` is high at a rising edge, every stage is emptied. After that edge `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: With no reads, the chain accepts exactly STAGES×DEPTH words before `wr_full` rises. `wr_full` then stays high until a read frees space.
- R3: A write offered while `wr_full` is high is ignored: no stored word is lost or replaced, and later reads return only the words that were accepted.
- R4: A read requested while `rd_empty` is high is ignored: `rd_data` keeps its previous value and `rd_empty` stays high.
- R5: Words leave the tail in exactly the order they entered the head.
- R6: A word written into an idle, empty chain makes `rd_empty` fall on the 2×(STAGES−1)-th rising edge after the edge that wrote it. Each boundary takes one clock to read the word and one clock to write it downstream.
- R7: `rd_data` is registered. It changes only on the rising edge at which an accepted read is sampled, and it shows the head word of the tail stage after that edge.
- R8: With writes and reads offered in any pattern, each internal boundary moves at most one word per clock. Once the chain is filled, it sustains one write and one read on every clock without `wr_full` rising or `rd_empty` rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all stages and boundaries |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe into the head stage |
| wr_data | input | WIDTH | Word offered to the head stage |
| wr_full | output | 1 | Head stage holds DEPTH words; writes are refused |
| rd_n | input | 1 | Active-low read strobe on the tail stage |
| rd_data | output | WIDTH | Registered word from the tail stage |
| rd_empty | output | 1 | Tail stage holds no word; reads are refused |

## Verification
The bench fills the chain to capacity with a stream of writes longer than the capacity. A design that miscounted in-flight words would accept more than STAGES×DEPTH words and overwrite one of them, or raise `wr_full` too early. It measures the edge count from one write to `rd_empty` falling, which catches a link that skipped its delay register or left a word stalled. It hammers reads while empty to expose a read port that re-presents stale memory. A long burst of random strobes then compares flags and data against a queue model on every clock, so an out-of-order or duplicated word at any boundary shows up as a data mismatch.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  localparam int unsigned DEF_WIDTH  = 18;
  localparam int unsigned DEF_DEPTH  = 8;
  localparam int unsigned DEF_STAGES = 4;

  // Bits needed to hold an occupancy value from 0 up to depth inclusive.
  function automatic int unsigned occ_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/fifo_chain_stage.sv
module fifo_chain_stage #(
  parameter int unsigned WIDTH = fifo_chain_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = fifo_chain_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_pend,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = fifo_chain_pkg::occ_bits(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic [CW:0]      occ;
  logic             wr_ok, rd_ok;

  assign wr_ok = wr_en && (cnt != CW'(DEPTH));
  assign rd_ok = rd_en && (cnt != '0);
  assign empty = (cnt == '0);
  // An incoming word already committed by the link counts as occupied.
  assign occ   = {1'b0, cnt} + {{CW{1'b0}}, wr_pend};
  assign full  = (occ >= (CW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp];
      end
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: a stage holding DEPTH words keeps that count unless it is read.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH)) && !rd_en |=> (cnt == CW'(DEPTH)));

  // R4: a read request on an empty stage leaves its output register alone.
  p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && rd_en |=> $stable(rd_data));

  // R2: occupancy never passes the stage depth.
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/fifo_chain_link.sv
module fifo_chain_link (
  input  logic clk,
  input  logic rst,
  input  logic up_empty,
  input  logic dn_full,
  output logic up_rd,
  output logic dn_wr
);
  logic up_empty_dly;
  logic dn_full_dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_empty_dly <= 1'b1;
      dn_full_dly  <= 1'b0;
    end else begin
      up_empty_dly <= up_empty;
      dn_full_dly  <= dn_full;
    end
  end

  assign up_rd = !up_empty && !dn_full;
  // The word read last clock now sits on the upstream output register.
  assign dn_wr = !up_empty_dly && !dn_full_dly;

  // R6: every upstream pull is pushed downstream on the very next clock.
  p_push_follows_pull_r6: assert property (@(posedge clk) disable iff (rst)
    up_rd |=> dn_wr);

  // R8: no downstream push without a pull one clock earlier.
  p_no_phantom_push_r8: assert property (@(posedge clk) disable iff (rst)
    dn_wr |-> $past(up_rd));
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain #(
  parameter int unsigned WIDTH  = fifo_chain_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH  = fifo_chain_pkg::DEF_DEPTH,
  parameter int unsigned STAGES = fifo_chain_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  input  logic             rd_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty
);
  localparam int unsigned LINKS = STAGES - 1;

  logic [WIDTH-1:0] st_din  [STAGES];
  logic [WIDTH-1:0] st_dout [STAGES];
  logic [STAGES-1:0] st_wr, st_rd, st_pend, st_empty, st_full;
  logic [LINKS-1:0]  lk_rd, lk_wr;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign st_wr[k]   = !wr_n;
      assign st_din[k]  = wr_data;
      assign st_pend[k] = 1'b0;
    end else begin : g_body
      assign st_wr[k]   = lk_wr[k-1];
      assign st_din[k]  = st_dout[k-1];
      assign st_pend[k] = lk_wr[k-1];
    end

    if (k == STAGES - 1) begin : g_tail
      assign st_rd[k] = !rd_n;
    end else begin : g_link
      fifo_chain_link u_link (
        .clk      (clk),
        .rst      (rst),
        .up_empty (st_empty[k]),
        .dn_full  (st_full[k+1]),
        .up_rd    (lk_rd[k]),
        .dn_wr    (lk_wr[k])
      );
      assign st_rd[k] = lk_rd[k];
    end

    fifo_chain_stage #(
      .WIDTH (WIDTH),
      .DEPTH (DEPTH)
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (st_wr[k]),
      .wr_data (st_din[k]),
      .wr_pend (st_pend[k]),
      .rd_en   (st_rd[k]),
      .rd_data (st_dout[k]),
      .empty   (st_empty[k]),
      .full    (st_full[k])
    );
  end

  assign wr_full  = st_full[0];
  assign rd_empty = st_empty[STAGES-1];
  assign rd_data  = st_dout[STAGES-1];

  // R1: the edge after a reset leaves the chain idle.
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (rd_empty && !wr_full && (rd_data == '0)));

  // R7: the output register moves only on an accepted read.
  p_rdata_moves_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !rd_empty) |=> $stable(rd_data));
endmodule

// File: tb/fifo_chain_tb.sv
module fifo_chain_tb;
  localparam int W      = 18;
  localparam int DEPTH  = 8;
  localparam int STAGES = 4;
  localparam int CAP    = STAGES * DEPTH;
  localparam time TCLK  = 10ns;
  localparam int LIMIT  = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic rd_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic wr_full, rd_empty;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_on = 1'b0;

  always #(TCLK/2) clk = ~clk;

  fifo_chain #(.WIDTH(W), .DEPTH(DEPTH), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .wr_full(wr_full),
    .rd_n(rd_n), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  // Behavioural reference: one queue per stage plus a word in flight per boundary.
  logic [W-1:0] q [STAGES][$];
  bit           pv [STAGES-1];
  logic [W-1:0] pd [STAGES-1];
  logic [W-1:0] m_rdata = '0;

  always @(posedge clk) begin
    bit emp [STAGES];
    bit fl  [STAGES];
    bit pull [STAGES-1];
    logic [W-1:0] tmp [STAGES-1];
    bit w, r;
    if (rst) begin
      for (int k = 0; k < STAGES; k++) q[k].delete();
      for (int k = 0; k < STAGES-1; k++) begin pv[k] = 0; pd[k] = '0; end
      m_rdata = '0;
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        emp[k] = (q[k].size() == 0);
        fl[k]  = (q[k].size() + ((k > 0 && pv[k-1]) ? 1 : 0)) >= DEPTH;
      end
      w = !wr_n && !fl[0];
      r = !rd_n && !emp[STAGES-1];
      for (int k = 0; k < STAGES-1; k++) begin
        pull[k] = !emp[k] && !fl[k+1];
        tmp[k]  = '0;
        if (pull[k]) tmp[k] = q[k].pop_front();
      end
      if (r) m_rdata = q[STAGES-1].pop_front();
      for (int k = 0; k < STAGES-1; k++) if (pv[k]) q[k+1].push_back(pd[k]);
      if (w) q[0].push_back(wr_data);
      for (int k = 0; k < STAGES-1; k++) begin pv[k] = pull[k]; pd[k] = tmp[k]; end
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 wr_full vs model", W'(wr_full), W'(q[0].size() >= DEPTH));
      chk("R8 rd_empty vs model", W'(rd_empty), W'(q[STAGES-1].size() == 0));
      chk("R5 rd_data vs model", rd_data, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d cycles expected<%0d", cyc, LIMIT);
      report();
      $finish;
    end
  end

  initial begin
    int n;
    int got;
    int prev_acc;
    logic [W-1:0] expv;
    logic [W-1:0] held;
    logic [15:0]  lfsr;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rd_empty after reset", W'(rd_empty), W'(1));
    chk("R1 wr_full after reset", W'(wr_full), W'(0));
    chk("R1 rd_data after reset", rd_data, '0);
    cmp_on = 1'b1;

    // R6: single-word latency through the chain
    wr_data = W'(18'h2A5A5);
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    n = 1;
    while (rd_empty && n < 100) begin @(negedge clk); n++; end
    chk("R6 edges from write to non-empty", W'(n - 1), W'(2 * (STAGES - 1)));

    // R7: read data registered, valid after the read edge
    rd_n = 1'b0;
    chk("R7 rd_data before read edge", rd_data, '0);
    @(negedge clk);
    rd_n = 1'b1;
    chk("R7 rd_data after read edge", rd_data, W'(18'h2A5A5));
    chk("R7 empty after last read", W'(rd_empty), W'(1));

    // R4: reads while empty ignored
    held = rd_data;
    rd_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R4 rd_data held on empty read", rd_data, held);
      chk("R4 rd_empty stays high", W'(rd_empty), W'(1));
    end
    rd_n = 1'b1;

    // R2/R3: overfill with more writes than capacity
    for (int i = 0; i < CAP + 8; i++) begin
      wr_data = W'(100 + i);
      wr_n = 1'b0;
      @(negedge clk);
    end
    wr_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 wr_full once capacity reached", W'(wr_full), W'(1));
    wr_data = W'(18'h3FFFF);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    chk("R2 wr_full held without reads", W'(wr_full), W'(1));

    // R5/R3: drain and check order and count
    rd_n = 1'b0;
    got = 0;
    expv = W'(100);
    prev_acc = !rd_empty;
    for (int i = 0; i < CAP + 2 * STAGES + 10; i++) begin
      @(negedge clk);
      if (prev_acc) begin
        chk("R5 drained word order", rd_data, expv);
        expv = expv + 1'b1;
        got++;
      end
      prev_acc = !rd_empty;
    end
    rd_n = 1'b1;
    chk("R3 words accepted equals capacity", W'(got), W'(CAP));
    chk("R3 chain empty after drain", W'(rd_empty), W'(1));

    // R8: sustained full-rate streaming after a partial fill
    for (int i = 0; i < 12; i++) begin
      wr_data = W'(500 + i); wr_n = 1'b0; @(negedge clk);
    end
    wr_n = 1'b1;
    repeat (10) @(negedge clk);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      wr_data = W'(700 + i); wr_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      if (rd_empty || wr_full) n++;
    end
    wr_n = 1'b1; rd_n = 1'b1;
    chk("R8 no stall during streaming", W'(n), W'(0));

    // R5/R8: random strobes, compared against the model each clock
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_data = W'(1000 + i);
      wr_n = (i % 1000 < 500) ? (lfsr[0] & lfsr[7]) : lfsr[0];
      rd_n = (i % 1000 < 500) ? lfsr[3] : (lfsr[3] | lfsr[9]);
      @(negedge clk);
    end
    wr_n = 1'b1;
    rd_n = 1'b0;
    repeat (CAP + 4 * STAGES + 10) @(negedge clk);
    rd_n = 1'b1;
    chk("R5 empty after final drain", W'(rd_empty), W'(1));

    // R1: reset mid-operation clears a non-empty chain
    wr_data = W'(77); wr_n = 1'b0;
    repeat (10) @(negedge clk);
    wr_n = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 empty after mid reset", W'(rd_empty), W'(1));
    chk("R1 rd_data after mid reset", rd_data, '0);
    repeat (2 * STAGES + 2) @(negedge clk);
    chk("R1 nothing surfaces after reset", W'(rd_empty), W'(1));

    report();
    $finish;
  end
endmodule